// File: doc/BRIEF.md
# Float and Integer Converter

This unit moves numbers between 16-bit two's-complement integers and a compact 16-bit floating-point code. In the float code the top bit is the sign. The next eight bits hold an exponent with a bias of 127. The low seven bits hold the fraction, and a leading one is implied above them. The code never rounds: any precision that is lost is simply cut off. The only value below the normal range is positive zero (all bits clear). The code has no infinities and no NaNs.

A one-bit opcode picks the direction. In float-to-integer mode the unit behaves like a C cast: the value is truncated toward zero, and it is clamped to the integer range when its magnitude is too large. In integer-to-float mode the unit takes the magnitude of the integer, finds its leading one, and shifts the magnitude into normalized position. It then builds the exponent from the position of that leading one.

The conversion logic is combinational. A single output register follows it, so each result appears one clock after its operand. Both directions share one left barrel shifter.

Top module: `fcvt_unit`

## Requirements
- R1: While reset is held low, the output is 0x0000 whatever the inputs are. After reset, the result for the operand applied before a rising edge appears on the output after that edge, which is one cycle of latency.
- R2: Opcode 0 selects float-to-integer and opcode 1 selects integer-to-float. The float fields are: bit 15 is the sign, bits 14:7 are the exponent with bias 127, and bits 6:0 are the fraction below an implied one. So 0x4040 converts to 3, and 3 converts to 0x4040.
- R3: Float-to-integer truncates toward zero when the magnitude lies between 1.0 and 2^15. For example, 0xC020 (-2.5) gives 0xFFFE (-2).
- R4: Float-to-integer gives 0x0000 for any exponent below 127. This covers 0x0000, 0x8000 and every magnitude below 1.0.
- R5: Float-to-integer saturates when the exponent is 142 or above. A positive sign gives 0x7FFF and a negative sign gives 0x8000, so 0xC700 (exactly -32768) comes out exact.
- R6: Integer-to-float of 0 gives 0x0000.
- R7: Integer-to-float of a nonzero value takes the magnitude (negating a negative input) and copies the input sign into bit 15. The exponent is 127 plus the bit position of the magnitude's leading one. The fraction is the seven bits below the leading one. For example, 0x8000 gives 0xC700 and 0xFFFF gives 0xBF80.
- R8: A magnitude with more than eight significant bits loses its low bits by truncation. For example, 257 gives 0x4380 (256.0) and 0x7FFF gives 0x46FF.
- R9: An integer with at most eight significant bits survives a round trip unchanged: integer-to-float followed by float-to-integer returns the original value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 1 | Direction select: 0 converts float to integer, 1 converts integer to float |
| data_i | input | 16 | Operand, either a float code or a two's-complement integer |
| data_o | output | 16 | Registered result of the conversion |

## Verification
Directed operands come first. They cover the format anchor 3 and 0x4040, negative fractions that show truncation toward zero rather than toward minus infinity, the exponent just below 127 against exactly 127, and the saturation threshold at exponent 142 with both signs. They also cover the most negative integer and wide integers whose low bits must be dropped. Round trips on small signed integers then tell a correct fraction alignment apart from one that is off by a single bit position. Finally, every one of the 65536 input codes is swept in each direction. The sweep catches an off-by-one in the leading-one position or the shift amount that would show up only in a few exponent bands.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    // Opcode for the conversion direction
    typedef enum logic {
        CVT_F2I = 1'b0,
        CVT_I2F = 1'b1
    } cvt_op_e;

endpackage

// File: rtl/fcvt_lead_one.sv
// Priority encoder: reports the position of the most significant set bit.
module fcvt_lead_one #(
    parameter int W     = 16,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [POS_W-1:0] pos_o,
    output logic             hit_o
);

    always_comb begin
        pos_o = '0;
        hit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                pos_o = POS_W'(i);
                hit_o = 1'b1;
            end
        end
    end

    // R7: the reported bit is set and nothing above it is set
    always_comb begin
        if (hit_o) begin
            a_r7_lead_one: assert (vec_i[pos_o] && ((vec_i >> pos_o) == W'(1)));
        end
    end

endmodule

// File: rtl/fcvt_shl.sv
// Logarithmic left barrel shifter, one stage per bit of the shift amount.
module fcvt_shl #(
    parameter int W     = 23,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     val_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     val_o
);

    logic [W-1:0] stage [AMT_W+1];

    assign stage[0] = val_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] << (2**s)) : stage[s];
    end

    assign val_o = stage[AMT_W];

endmodule

// File: rtl/fcvt_unit.sv
// Float <-> integer converter with one output register.
// INT_W must equal 1 + EXP_W + FRAC_W.
module fcvt_unit
    import fcvt_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             op_i,
    input  logic [INT_W-1:0] data_i,
    output logic [INT_W-1:0] data_o
);

    localparam int SH_W  = INT_W + FRAC_W;
    localparam int AMT_W = $clog2(SH_W);
    localparam int POS_W = $clog2(INT_W);
    localparam int BIAS  = 2**(EXP_W-1) - 1;

    localparam logic [EXP_W-1:0] BIAS_V  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] SAT_EXP = EXP_W'(BIAS + INT_W - 1);
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic [INT_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    cvt_op_e op_sel;
    assign op_sel = cvt_op_e'(op_i);

    // Float fields
    logic              f_sign;
    logic [EXP_W-1:0]  f_exp;
    logic [FRAC_W-1:0] f_frac;
    logic [EXP_W-1:0]  f_k_full;
    logic              f_under, f_over;

    assign f_sign   = data_i[INT_W-1];
    assign f_exp    = data_i[INT_W-2 -: EXP_W];
    assign f_frac   = data_i[FRAC_W-1:0];
    assign f_k_full = f_exp - BIAS_V;
    assign f_under  = (f_exp < BIAS_V);
    assign f_over   = (f_exp >= SAT_EXP);

    // Integer magnitude and leading one
    logic             i_sign;
    logic [INT_W-1:0] i_mag;
    logic [POS_W-1:0] i_pos;
    logic             i_hit;

    assign i_sign = data_i[INT_W-1];
    assign i_mag  = i_sign ? (~data_i + 1'b1) : data_i;

    fcvt_lead_one #(
        .W     (INT_W),
        .POS_W (POS_W)
    ) u_lead (
        .vec_i (i_mag),
        .pos_o (i_pos),
        .hit_o (i_hit)
    );

    // Shared shifter: operand and amount chosen by direction
    logic [SH_W-1:0]  sh_in_d, sh_out_d;
    logic [AMT_W-1:0] sh_amt_d;

    always_comb begin
        if (op_sel == CVT_F2I) begin
            sh_in_d  = SH_W'({1'b1, f_frac});
            sh_amt_d = f_k_full[AMT_W-1:0];
        end else begin
            sh_in_d  = SH_W'(i_mag);
            sh_amt_d = AMT_W'(INT_W-1) - AMT_W'(i_pos);
        end
    end

    fcvt_shl #(
        .W     (SH_W),
        .AMT_W (AMT_W)
    ) u_shl (
        .val_i (sh_in_d),
        .amt_i (sh_amt_d),
        .val_o (sh_out_d)
    );

    // Result assembly
    logic [INT_W-2:0]  f2i_mag_d;
    logic [INT_W-1:0]  f2i_res_d, i2f_res_d;
    logic [EXP_W-1:0]  i2f_exp_d;
    logic [FRAC_W-1:0] i2f_frac_d;

    always_comb begin
        f2i_mag_d = sh_out_d[FRAC_W +: INT_W-1];
        if (f_under) begin
            f2i_res_d = '0;
        end else if (f_over) begin
            f2i_res_d = f_sign ? INT_MIN : INT_MAX;
        end else if (f_sign) begin
            f2i_res_d = ~{1'b0, f2i_mag_d} + 1'b1;
        end else begin
            f2i_res_d = {1'b0, f2i_mag_d};
        end

        i2f_exp_d  = BIAS_V + EXP_W'(i_pos);
        i2f_frac_d = sh_out_d[INT_W-2 -: FRAC_W];
        i2f_res_d  = i_hit ? {i_sign, i2f_exp_d, i2f_frac_d} : '0;

        state_d.res = (op_sel == CVT_F2I) ? f2i_res_d : i2f_res_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign data_o = state_q.res;

    logic unused_bits;
    assign unused_bits = ^{sh_out_d[SH_W-1], sh_out_d[FRAC_W-1:0], f_k_full[EXP_W-1:AMT_W]};

    // Assertions
    a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> data_o == '0);

    a_r4_below_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 1'b0 && data_i[INT_W-2 -: EXP_W] < BIAS_V) |=> data_o == '0);

    a_r5_pos_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 1'b0 && !data_i[INT_W-1] && data_i[INT_W-2 -: EXP_W] >= SAT_EXP)
        |=> data_o == INT_MAX);

    a_r5_neg_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 1'b0 && data_i[INT_W-1] && data_i[INT_W-2 -: EXP_W] >= SAT_EXP)
        |=> data_o == INT_MIN);

    a_r6_zero_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 1'b1 && data_i == '0) |=> data_o == '0);

    a_r7_sign_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 1'b1 && data_i != '0) |=> data_o[INT_W-1] == $past(data_i[INT_W-1]));

endmodule

// File: tb/sim_fcvt_unit.sv
module sim_fcvt_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    logic [15:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcvt_unit u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .op_i   (op),
        .data_i (din),
        .data_o (dout)
    );

    function automatic logic [15:0] ref_f2i(input logic [15:0] f);
        int s = f[15];
        int e = f[14:7];
        int t = f[6:0];
        int mag;
        if (e < 127) return 16'h0000;
        if (e - 127 >= 15) return s ? 16'h8000 : 16'h7FFF;
        mag = ((128 + t) << (e - 127)) >> 7;
        return s ? 16'(-mag) : 16'(mag);
    endfunction

    function automatic logic [15:0] ref_i2f(input logic [15:0] v);
        int s = v[15];
        int mag = s ? 65536 - int'(v) : int'(v);
        int p = 0;
        int t;
        if (v == 16'h0000) return 16'h0000;
        while ((mag >> (p + 1)) != 0) p++;
        t = (p >= 7) ? ((mag >> (p - 7)) & 127) : ((mag << (7 - p)) & 127);
        return {s[0], 8'(127 + p), 7'(t)};
    endfunction

    function automatic string classify(input logic o, input logic [15:0] v);
        int mag;
        if (!o) begin
            if (v[14:7] < 8'd127) return "R4";
            if (v[14:7] >= 8'd142) return "R5";
            return "R3";
        end
        if (v == 16'h0000) return "R6";
        mag = v[15] ? 65536 - int'(v) : int'(v);
        return (mag >= 256) ? "R8" : "R7";
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step(input logic o, input logic [15:0] v, input string tag);
        string t = (tag == "") ? classify(o, v) : tag;
        exp_q.push_back(o ? ref_i2f(v) : ref_f2i(v));
        op  = o;
        din = v;
        @(negedge clk);
        check(dout, exp_q.pop_front(), t);
    endtask

    task automatic round_trip(input logic [15:0] v);
        logic [15:0] f;
        step(1'b1, v, "R7");
        f = dout;
        step(1'b0, f, "R3");
        check(dout, v, "R9");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // R1: inputs during reset are ignored
        op  = 1'b1;
        din = 16'h0003;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout, 16'h0000, "R1");
        rst_n = 1'b1;

        // R1 latency and R2 format anchors
        step(1'b0, 16'h4040, "R2");
        step(1'b1, 16'h0003, "R2");
        step(1'b0, 16'h3F80, "R1");

        // Float to integer corners
        step(1'b0, 16'hC020, "R3");
        step(1'b0, 16'h46FF, "R3");
        step(1'b0, 16'hC140, "R3");
        step(1'b0, 16'h3F7F, "R4");
        step(1'b0, 16'h0000, "R4");
        step(1'b0, 16'h8000, "R4");
        step(1'b0, 16'hBF00, "R4");
        step(1'b0, 16'h4700, "R5");
        step(1'b0, 16'hC700, "R5");
        step(1'b0, 16'h7F7F, "R5");
        step(1'b0, 16'hFF00, "R5");

        // Integer to float corners
        step(1'b1, 16'h0000, "R6");
        step(1'b1, 16'h0001, "R7");
        step(1'b1, 16'hFFFF, "R7");
        step(1'b1, 16'h8000, "R7");
        step(1'b1, 16'h0101, "R8");
        step(1'b1, 16'h7FFF, "R8");
        step(1'b1, 16'hFEFF, "R8");

        // R9 round trips
        round_trip(16'd1);
        round_trip(-16'sd5);
        round_trip(16'd100);
        round_trip(16'd255);
        round_trip(-16'sd128);
        round_trip(-16'sd255);

        // Full sweep in both directions
        for (int i = 0; i < 65536; i++) begin
            step(1'b0, 16'(i), "");
            step(1'b1, 16'(i), "");
        end

        finish_run();
    end

endmodule